// File: doc/BRIEF.md
# Aligned-Boundary Read Burst Sequencer

This block sequences the data phases of a read that a bridge issues as bus master. When a request is accepted, it decides how many dwords to fetch. Configuration and I/O reads, and memory reads without a prefetch grant, fetch one dword. Every other read runs to the next aligned boundary. The boundary size depends on the command and on the cache line size register. The block then counts data phases, advancing only on cycles where the target is ready. It raises a last-phase flag on the final transfer so the master stops on the boundary. One cycle after that transfer it emits a done pulse carrying the number of dwords moved.

The controller is built around three states:
- `ST_IDLE` waits for `start_i`. The transition *accept* goes to `ST_BURST` and loads the length, address and counters.
- `ST_BURST` runs data phases. The transition *final transfer* (ready while on the last phase) goes to `ST_DONE`. A ready-low cycle *stall* stays in `ST_BURST`.
- `ST_DONE` holds for one cycle, and the transition *retire* returns to `ST_IDLE`.

Top module: `rd_burst_seq`

## Requirements
- R1: A configuration read (`cmd_i`=0) or an I/O read (`cmd_i`=1) transfers exactly one dword, whatever the other inputs are. Codes 5 to 7 also transfer one dword.
- R2: A memory read (`cmd_i`=2) transfers exactly one dword in two cases: downstream (`upstream_i`=0) with `pref_space_i`=0, and upstream (`upstream_i`=1) with `up_pref_en_i`=0.
- R3: A memory read prefetches to its boundary in two cases: downstream with `pref_space_i`=1, and upstream with `up_pref_en_i`=1.
- R4: A memory read line (`cmd_i`=3) or a memory read multiple (`cmd_i`=4) always prefetches, ignoring `pref_space_i`, `upstream_i` and `up_pref_en_i`.
- R5: For a prefetching memory read or memory read line, the boundary block is 16 dwords when `cls_i` is 0 or 16. When `cls_i` is 1, 2, 4 or 8, the block is `cls_i` dwords.
- R6: For a memory read multiple, the boundary block is 32 dwords when `cls_i` is 0 or 16. Otherwise it is twice `cls_i` dwords.
- R7: A prefetching burst length equals the block size minus the start dword address modulo the block size. A start on a boundary therefore fetches a full block.
- R8: Any `cls_i` value other than 0, 1, 2, 4, 8 and 16 behaves as 0.
- R9: `xfer_addr_o` starts at the captured start address and increments by one only after a cycle in which `xfer_active_o` and `rdy_i` are both high. With `rdy_i` low, no phase is counted.
- R10: `last_phase_o` is high exactly in the burst cycles where the pending transfer is the final one.
- R11: `done_o` pulses for one cycle, in the cycle after the final transfer. With it, `done_count_o` gives the total dwords transferred, and the block is idle in the following cycle.
- R12: `start_i` is ignored while `busy_o` is high, and the running burst is unaffected.
- R13: After reset, `busy_o`, `xfer_active_o`, `last_phase_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request accept strobe, sampled in idle |
| start_addr_i | input | ADDR_W | Start dword address |
| cmd_i | input | 3 | Read command code |
| pref_space_i | input | 1 | Address lies in prefetchable space |
| upstream_i | input | 1 | Request travels upstream |
| up_pref_en_i | input | 1 | Upstream memory read prefetch enable |
| cls_i | input | CLS_W | Cache line size in dwords |
| rdy_i | input | 1 | Target ready for the current data phase |
| busy_o | output | 1 | Block not idle |
| xfer_active_o | output | 1 | Data phase pending |
| xfer_addr_o | output | ADDR_W | Dword address of pending phase |
| last_phase_o | output | 1 | Pending phase is the last |
| done_o | output | 1 | One-cycle completion pulse |
| done_count_o | output | CNT_W | Dwords transferred, valid with done_o |

## Verification
Suppose the length decoder picks the wrong block or offset. The fault shows at the first `last_phase_o` of that burst: the flag comes too early or never on the expected phase. `done_count_o` then disagrees in the cycle after the final transfer. An address counter that slips during a stall shows at once as a wrong `xfer_addr_o` on the next pending phase. A state register that leaks through `ST_DONE` or takes a `start_i` while busy shows within one cycle. The symptom is either a `done_o` pulse longer than one cycle or a burst with no request queued behind it.

// File: rtl/rd_burst_pkg.sv
package rd_burst_pkg;

    localparam int MAX_BLK_LOG = 5;                 // largest block: 32 dwords
    localparam int CNT_W       = MAX_BLK_LOG + 1;   // holds 1..32

    localparam logic [2:0] CMD_CFG_RD   = 3'd0;
    localparam logic [2:0] CMD_IO_RD    = 3'd1;
    localparam logic [2:0] CMD_MEM_RD   = 3'd2;
    localparam logic [2:0] CMD_MEM_LINE = 3'd3;
    localparam logic [2:0] CMD_MEM_MULT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DONE  = 2'd2
    } bst_state_e;

endpackage

// File: rtl/rd_burst_len_calc.sv
module rd_burst_len_calc
    import rd_burst_pkg::*;
#(
    parameter int CLS_W = 8
) (
    input  logic [2:0]       cmd_i,
    input  logic             pref_space_i,
    input  logic             upstream_i,
    input  logic             up_pref_en_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [CNT_W-1:0] addr_lo_i,
    output logic             prefetch_o,
    output logic [CNT_W-1:0] len_o
);

    logic [2:0]       line_log;
    logic [2:0]       blk_log;
    logic [CNT_W-1:0] blk_size;
    logic [CNT_W-1:0] blk_mask;
    logic [CNT_W-1:0] offset;

    // prefetch decision from command and space attributes
    always_comb begin
        case (cmd_i)
            CMD_MEM_RD:   prefetch_o = upstream_i ? up_pref_en_i : pref_space_i;
            CMD_MEM_LINE: prefetch_o = 1'b1;
            CMD_MEM_MULT: prefetch_o = 1'b1;
            default:      prefetch_o = 1'b0;
        endcase
    end

    // cache line size to log2 of line, unsupported values fold to 16
    always_comb begin
        if (cls_i == CLS_W'(1))      line_log = 3'd0;
        else if (cls_i == CLS_W'(2)) line_log = 3'd1;
        else if (cls_i == CLS_W'(4)) line_log = 3'd2;
        else if (cls_i == CLS_W'(8)) line_log = 3'd3;
        else                         line_log = 3'd4;
    end

    always_comb begin
        blk_log  = line_log + ((cmd_i == CMD_MEM_MULT) ? 3'd1 : 3'd0);
        blk_size = CNT_W'(1) << blk_log;
        blk_mask = blk_size - CNT_W'(1);
        offset   = addr_lo_i & blk_mask;
        len_o    = prefetch_o ? (blk_size - offset) : CNT_W'(1);
    end

endmodule

// File: rtl/rd_burst_phase_ctr.sv
module rd_burst_phase_ctr
    import rd_burst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [CNT_W-1:0]  load_len_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  xfer_cnt_o,
    output logic              is_last_o
);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining  <= '0;
            cur_addr_o <= '0;
            xfer_cnt_o <= '0;
        end else if (load_i) begin
            remaining  <= load_len_i;
            cur_addr_o <= load_addr_i;
            xfer_cnt_o <= '0;
        end else if (adv_i) begin
            remaining  <= remaining - CNT_W'(1);
            cur_addr_o <= cur_addr_o + ADDR_W'(1);
            xfer_cnt_o <= xfer_cnt_o + CNT_W'(1);
        end
    end

    assign is_last_o = (remaining == CNT_W'(1));

    // R9: address steps by one per accepted phase
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (cur_addr_o == $past(cur_addr_o) + ADDR_W'(1)));

    // R9: no movement without an accepted phase or a load
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(cur_addr_o));

endmodule

// File: rtl/rd_burst_fsm.sv
module rd_burst_fsm
    import rd_burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rdy_i,
    input  logic is_last_i,
    output logic load_o,
    output logic adv_o,
    output logic active_o,
    output logic busy_o,
    output logic done_o
);

    bst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load_o   = 1'b0;
        adv_o    = 1'b0;
        active_o = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                if (start_i) begin          // accept
                    load_o  = 1'b1;
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                active_o = 1'b1;
                adv_o    = rdy_i;
                if (rdy_i && is_last_i)     // final transfer
                    state_d = ST_DONE;
            end
            ST_DONE: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;          // retire
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: completion follows an accepted final phase
    p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && is_last_i) |=> done_o);

    // R12: a start while busy never returns the block to idle early
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && start_i && !(rdy_i && is_last_i)) |=> active_o);

endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
    import rd_burst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [2:0]        cmd_i,
    input  logic              pref_space_i,
    input  logic              upstream_i,
    input  logic              up_pref_en_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic              rdy_i,
    output logic              busy_o,
    output logic              xfer_active_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic              last_phase_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  done_count_o
);

    logic             load;
    logic             adv;
    logic             is_last;
    logic             prefetch;
    logic             prefetch_q;
    logic [CNT_W-1:0] len;

    rd_burst_len_calc #(.CLS_W(CLS_W)) i_len (
        .cmd_i        (cmd_i),
        .pref_space_i (pref_space_i),
        .upstream_i   (upstream_i),
        .up_pref_en_i (up_pref_en_i),
        .cls_i        (cls_i),
        .addr_lo_i    (start_addr_i[CNT_W-1:0]),
        .prefetch_o   (prefetch),
        .len_o        (len)
    );

    rd_burst_phase_ctr #(.ADDR_W(ADDR_W)) i_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_addr_i (start_addr_i),
        .load_len_i  (len),
        .adv_i       (adv),
        .cur_addr_o  (xfer_addr_o),
        .xfer_cnt_o  (done_count_o),
        .is_last_o   (is_last)
    );

    rd_burst_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rdy_i     (rdy_i),
        .is_last_i (is_last),
        .load_o    (load),
        .adv_o     (adv),
        .active_o  (xfer_active_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    assign last_phase_o = xfer_active_o && is_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prefetch_q <= 1'b0;
        else if (load) prefetch_q <= prefetch;
    end

    // R1 / R2: a non-prefetching read finishes after a single dword
    p_single_dword_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !prefetch_q) |-> (done_count_o == CNT_W'(1)));

    // R7: any burst length lies within one largest block
    p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (done_count_o != '0 && done_count_o <= CNT_W'(32)));

    // R10: last flag only during a pending phase
    p_last_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        last_phase_o |-> (xfer_active_o && !done_o));

endmodule

// File: tb/test_rd_burst_seq.sv
module test_rd_burst_seq;

    localparam int ADDR_W = 32;
    localparam int CLS_W  = 8;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [2:0]        cmd = '0;
    logic              pref_space = 1'b0;
    logic              upstream = 1'b0;
    logic              up_pref_en = 1'b0;
    logic [CLS_W-1:0]  cls = '0;
    logic              rdy = 1'b0;
    logic              busy, xfer_active, last_phase, done;
    logic [ADDR_W-1:0] xfer_addr;
    logic [CNT_W-1:0]  done_count;

    int tests  = 0;
    int errors = 0;
    int rdy_mode = 0;
    int seen = 0;

    typedef struct {
        int              len;
        logic [ADDR_W-1:0] addr;
        string           tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    rd_burst_seq #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) i_rd_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .cmd_i(cmd), .pref_space_i(pref_space), .upstream_i(upstream),
        .up_pref_en_i(up_pref_en), .cls_i(cls), .rdy_i(rdy),
        .busy_o(busy), .xfer_active_o(xfer_active), .xfer_addr_o(xfer_addr),
        .last_phase_o(last_phase), .done_o(done), .done_count_o(done_count)
    );

    function automatic void check(bit ok, string tag, longint act, longint exp);
        tests++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    // independent reference for the burst length
    function automatic int model_len(logic [2:0] c, bit ps, bit up, bit en,
                                     int cl, logic [ADDR_W-1:0] a);
        bit pf;
        int line, blk;
        pf = (c == 3'd3) || (c == 3'd4) || ((c == 3'd2) && (up ? en : ps));
        if (!pf) return 1;
        line = (cl == 1 || cl == 2 || cl == 4 || cl == 8) ? cl : 16;
        blk  = (c == 3'd4) ? 2 * line : line;
        return blk - int'(a % blk);
    endfunction

    // ready pattern generator
    initial begin
        forever begin
            @(posedge clk); #2;
            case (rdy_mode)
                0:       rdy = 1'b1;
                1:       rdy = ($urandom % 3) != 0;
                default: rdy = ($urandom % 4) == 0;
            endcase
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (xfer_active) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R12 unexpected burst", 1, 0);
                    end else begin
                        check(xfer_addr == exp_q[0].addr + ADDR_W'(seen),
                              {exp_q[0].tag, " R9 addr"}, xfer_addr,
                              exp_q[0].addr + ADDR_W'(seen));
                        check(last_phase == (seen + 1 == exp_q[0].len),
                              {exp_q[0].tag, " R10 last"}, last_phase,
                              seen + 1 == exp_q[0].len);
                        if (rdy) seen++;
                    end
                end
                if (done) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R11 unexpected done", 1, 0);
                    end else begin
                        check(int'(done_count) == exp_q[0].len,
                              {exp_q[0].tag, " R11 count"}, done_count, exp_q[0].len);
                        check(seen == exp_q[0].len, {exp_q[0].tag, " R9 phases"},
                              seen, exp_q[0].len);
                        void'(exp_q.pop_front());
                        seen = 0;
                    end
                end
            end
        end
    end

    task automatic issue(logic [2:0] c, bit ps, bit up, bit en, int cl,
                         logic [ADDR_W-1:0] a, string tag);
        exp_t e;
        e.len  = model_len(c, ps, up, en, cl, a);
        e.addr = a;
        e.tag  = tag;
        exp_q.push_back(e);
        @(posedge clk); #2;
        start = 1'b1; cmd = c; pref_space = ps; upstream = up;
        up_pref_en = en; cls = CLS_W'(cl); start_addr = a;
        @(posedge clk); #2;
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic expect_len(logic [2:0] c, bit ps, bit up, bit en, int cl,
                              logic [ADDR_W-1:0] a, int want, string tag);
        check(model_len(c, ps, up, en, cl, a) == want, {tag, " model"},
              model_len(c, ps, up, en, cl, a), want);
        issue(c, ps, up, en, cl, a, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R13 reset state
        check(!busy && !xfer_active && !last_phase && !done, "R13 reset",
              {busy, xfer_active, last_phase, done}, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(!busy && !done, "R13 after release", {busy, done}, 0);

        rdy_mode = 0;
        expect_len(3'd0, 1, 0, 1, 16, 32'h13,  1, "R1 cfg");
        expect_len(3'd1, 1, 1, 1, 8,  32'h20,  1, "R1 io");
        expect_len(3'd6, 1, 0, 1, 0,  32'h0,   1, "R1 code6");
        expect_len(3'd2, 0, 0, 1, 0,  32'h100, 1, "R2 mr down np");
        expect_len(3'd2, 1, 1, 0, 0,  32'h100, 1, "R2 mr up off");
        expect_len(3'd2, 1, 0, 0, 0,  32'h105, 11, "R3 R5 mr down pf");
        expect_len(3'd2, 0, 1, 1, 8,  32'h3,   5, "R3 mr up en");
        expect_len(3'd3, 0, 0, 0, 4,  32'h22,  2, "R4 R5 mrl np");
        expect_len(3'd3, 0, 1, 0, 16, 32'h40,  16, "R5 R7 mrl aligned");
        expect_len(3'd4, 0, 0, 0, 0,  32'h7,   25, "R4 R6 mrm cls0");
        expect_len(3'd4, 1, 0, 0, 2,  32'h5,   3, "R6 mrm cls2");
        expect_len(3'd4, 1, 0, 0, 1,  32'h9,   1, "R6 mrm cls1");
        expect_len(3'd4, 1, 0, 0, 8,  32'h30,  16, "R6 R7 mrm aligned");
        expect_len(3'd2, 1, 0, 0, 3,  32'h2,   14, "R8 cls3");
        expect_len(3'd4, 0, 0, 0, 32, 32'hFFFF_FFE0, 32, "R8 cls32");

        // stalls
        rdy_mode = 1;
        expect_len(3'd4, 0, 0, 0, 0,  32'h1,   31, "R9 stall mrm");
        expect_len(3'd3, 0, 0, 0, 8,  32'h6,   2, "R9 stall mrl");

        // R12: a start during a running burst is ignored
        rdy_mode = 2;
        begin
            exp_t e;
            e.len = 16; e.addr = 32'h200; e.tag = "R12 busy start";
            exp_q.push_back(e);
            @(posedge clk); #2;
            start = 1'b1; cmd = 3'd3; pref_space = 0; upstream = 0;
            up_pref_en = 0; cls = 0; start_addr = 32'h200;
            @(posedge clk); #2;
            start = 1'b0;
            repeat (3) @(posedge clk);
            #2;
            start = 1'b1; cmd = 3'd4; cls = 0; start_addr = 32'h500;
            @(posedge clk); #2;
            start = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check(!busy && !xfer_active, "R12 no second burst",
                  {busy, xfer_active}, 0);
        end

        // mixed traffic
        rdy_mode = 1;
        for (int i = 0; i < 40; i++) begin
            logic [2:0] c;
            int cl;
            c = 3'($urandom % 8);
            case ($urandom % 8)
                0: cl = 0; 1: cl = 1; 2: cl = 2; 3: cl = 4;
                4: cl = 8; 5: cl = 16; 6: cl = 5; default: cl = 255;
            endcase
            issue(c, 1'($urandom), 1'($urandom), 1'($urandom), cl,
                  32'($urandom), "R7 mixed");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

endmodule